// File: doc/BRIEF.md
# Pointer-Addressed Parallel Host Register Port

This block lets an external processor configure a bank of internal byte registers over an 8-bit asynchronous port. The host has two active-low strobes, one for reads and one for writes, a select pin `dsel`, and a shared bidirectional data bus. A write with `dsel` low loads the bus value into a pointer register. A write with `dsel` high stores the bus value into the register that the pointer names. A read returns either the pointer (`dsel` low) or the named register (`dsel` high). The pointer never advances by itself, so the host can access one register many times after setting the pointer once.

The strobes are brought into the system clock domain through a two-stage synchronizer. A small state machine has four states:

- `S_IDLE`: waiting for a strobe.
- `S_WRITE`: the write strobe is low; the bus and select are sampled every cycle.
- `S_COMMIT`: a single cycle in which the update takes effect.
- `S_READ`: the read strobe is low.

The transitions are:

- `S_IDLE`→`S_WRITE` when the synchronized write strobe falls.
- `S_IDLE`→`S_READ` when the read strobe falls.
- `S_WRITE`→`S_COMMIT` when the write strobe rises.
- `S_COMMIT`→`S_IDLE` unconditionally.
- `S_READ`→`S_IDLE` when the read strobe rises.
- Any state → `S_IDLE` when serial mode is selected.

Register 15 holds the device address for a serial two-wire host link, which is built outside this block. When `serial_mode` is high, the parallel strobes are ignored and the data pins become general-purpose I/O. A direction register (12) and an output register (13) control the pins. A read-only input register (14) samples the pins.

Top module: `host_regport`

## Requirements
- R1: While reset is low, the pointer is 0x00, register 15 holds 0x2A, every other register holds 0x00, and the block drives no bus bit.
- R2: A write strobe pulse with `dsel` low loads the bus byte into the pointer.
- R3: A write strobe pulse with `dsel` high stores the bus byte into the pointed register only after the strobe returns high; the register keeps its old value while the strobe is still low.
- R4: A read with `dsel` high drives the pointed register's value onto the bus.
- R5: A read with `dsel` low drives the pointer value onto the bus.
- R6: The pointer keeps its value across data reads and data writes, so consecutive data writes land in the same register.
- R7: In parallel mode the bus is driven only while `rd_n` is low.
- R8: A pointer value of 16 or more selects no register: data writes have no effect and data reads return 0x00.
- R9: Register 15 appears on the `dev_addr` output.
- R10: While `serial_mode` is high, strobes have no effect. Each bus bit whose bit in register 12 is 1 is driven with the matching bit of register 13.
- R11: Register 14 is read-only. While `serial_mode` is high it captures the bus pins through a two-stage synchronizer, and it holds its value after parallel mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| dsel | input | 1 | Low selects the pointer; high selects the pointed register |
| serial_mode | input | 1 | High selects serial mode with GPIO use of the bus |
| hbus | inout | 8 | Bidirectional host data bus |
| dev_addr | output | 8 | Serial-link device address (register 15) |
| cfg_bus | output | 128 | All registers, with register i at bits [8i+7:8i] |

## Verification
The bench uses the default parameters: 8-bit data, 16 registers, GPIO registers at 12, 13 and 14, the device address at 15, and two synchronizer stages. With 16 registers and an 8-bit pointer, pointer values 0x10 to 0xFF are unmapped, so the bench can test the out-of-range behaviour. Placing the GPIO and device-address registers at the top of the bank lets one bench cover pointer loads, the in-range and out-of-range edge at 0x0F/0x10, and the return from serial mode.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WRITE  = 2'd1,
        S_COMMIT = 2'd2,
        S_READ   = 2'd3
    } hrp_state_e;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
    import hrp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_s,
    input  logic          rd_s,
    input  logic          serial_mode,
    input  logic [DW-1:0] bus_in,
    input  logic          sel_in,
    output logic          commit,
    output logic [DW-1:0] cap_data,
    output logic          cap_sel,
    output hrp_state_e    state
);
    hrp_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (serial_mode)  nxt = S_IDLE;
                else if (!wr_s)   nxt = S_WRITE;
                else if (!rd_s)   nxt = S_READ;
            end
            S_WRITE: begin
                if (serial_mode)  nxt = S_IDLE;
                else if (wr_s)    nxt = S_COMMIT;
            end
            S_COMMIT: nxt = S_IDLE;
            S_READ: begin
                if (serial_mode || rd_s) nxt = S_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        commit = 1'b0;
        unique case (state)
            S_IDLE:   commit = 1'b0;
            S_WRITE:  commit = 1'b0;
            S_COMMIT: commit = 1'b1;
            S_READ:   commit = 1'b0;
        endcase
    end

    // Bus and select sampled each cycle the write strobe is seen low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_data <= '0;
            cap_sel  <= 1'b0;
        end else if (nxt == S_WRITE) begin
            cap_data <= bus_in;
            cap_sel  <= sel_in;
        end
    end
endmodule

// File: rtl/hrp_regbank.sv
module hrp_regbank #(
    parameter int          DW            = 8,
    parameter int          NREG          = 16,
    parameter int          GPIO_DIR_IDX  = 12,
    parameter int          GPIO_OUT_IDX  = 13,
    parameter int          GPIO_IN_IDX   = 14,
    parameter int          DEV_ADDR_IDX  = 15,
    parameter logic [DW-1:0] DEV_ADDR_INIT = 8'h2A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             cap_sel,
    input  logic [DW-1:0]    cap_data,
    input  logic             serial_mode,
    input  logic [DW-1:0]    pins_s,
    input  logic             rd_sel,
    output logic [DW-1:0]    ptr,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    gpio_dir,
    output logic [DW-1:0]    gpio_out,
    output logic [DW-1:0]    dev_addr,
    output logic [NREG*DW-1:0] regs_flat
);
    localparam int            IW     = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [DW-1:0] NREG_V = DW'(NREG);

    logic [DW-1:0] regv [NREG];
    logic          hit;

    assign hit = (ptr < NREG_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ptr <= '0;
        else if (commit && !cap_sel) ptr <= cap_data;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == GPIO_IN_IDX) begin : g_in
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           regv[i] <= '0;
                else if (serial_mode) regv[i] <= pins_s;
            end
        end else begin : g_rw
            localparam logic [DW-1:0] INIT = (i == DEV_ADDR_IDX) ? DEV_ADDR_INIT : '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regv[i] <= INIT;
                else if (commit && cap_sel && (ptr == DW'(i)))
                    regv[i] <= cap_data;
            end
        end
        assign regs_flat[i*DW +: DW] = regv[i];
    end

    always_comb begin
        if (!rd_sel)  rdata = ptr;
        else if (hit) rdata = regv[ptr[IW-1:0]];
        else          rdata = '0;
    end

    assign gpio_dir = regv[GPIO_DIR_IDX];
    assign gpio_out = regv[GPIO_OUT_IDX];
    assign dev_addr = regv[DEV_ADDR_IDX];
endmodule

// File: rtl/host_regport.sv
module host_regport
    import hrp_pkg::*;
#(
    parameter int            DW            = 8,
    parameter int            NREG          = 16,
    parameter int            SYNC_STAGES   = 2,
    parameter int            GPIO_DIR_IDX  = 12,
    parameter int            GPIO_OUT_IDX  = 13,
    parameter int            GPIO_IN_IDX   = 14,
    parameter int            DEV_ADDR_IDX  = 15,
    parameter logic [DW-1:0] DEV_ADDR_INIT = 8'h2A
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 dsel,
    input  logic                 serial_mode,
    inout  wire  [DW-1:0]        hbus,
    output logic [DW-1:0]        dev_addr,
    output logic [NREG*DW-1:0]   cfg_bus
);
    logic [1:0]    strb_s;
    logic          commit, cap_sel;
    logic [DW-1:0] cap_data, ptr, rdata, gpio_dir, gpio_out, pins_s;
    logic [DW-1:0] bus_en, bus_out;
    hrp_state_e    state;

    hrp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .d({wr_n, rd_n}), .q(strb_s)
    );

    hrp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(hbus), .q(pins_s)
    );

    hrp_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_s(strb_s[1]), .rd_s(strb_s[0]),
        .serial_mode(serial_mode), .bus_in(hbus), .sel_in(dsel),
        .commit(commit), .cap_data(cap_data), .cap_sel(cap_sel), .state(state)
    );

    hrp_regbank #(
        .DW(DW), .NREG(NREG),
        .GPIO_DIR_IDX(GPIO_DIR_IDX), .GPIO_OUT_IDX(GPIO_OUT_IDX),
        .GPIO_IN_IDX(GPIO_IN_IDX), .DEV_ADDR_IDX(DEV_ADDR_IDX),
        .DEV_ADDR_INIT(DEV_ADDR_INIT)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cap_sel(cap_sel),
        .cap_data(cap_data), .serial_mode(serial_mode), .pins_s(pins_s),
        .rd_sel(dsel), .ptr(ptr), .rdata(rdata), .gpio_dir(gpio_dir),
        .gpio_out(gpio_out), .dev_addr(dev_addr), .regs_flat(cfg_bus)
    );

    // Drive enables: read data in parallel mode, per-bit GPIO in serial mode
    always_comb begin
        if (!rst_n) begin
            bus_en  = '0;
            bus_out = '0;
        end else if (serial_mode) begin
            bus_en  = gpio_dir;
            bus_out = gpio_out;
        end else begin
            bus_en  = {DW{~rd_n}};
            bus_out = rdata;
        end
    end

    for (genvar b = 0; b < DW; b++) begin : g_pad
        assign hbus[b] = bus_en[b] ? bus_out[b] : 1'bz;
    end
endmodule

// File: rtl/hrp_chk.sv
module hrp_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          serial_mode,
    input logic          rd_n,
    input logic [DW-1:0] bus_en,
    input logic [DW-1:0] ptr,
    input logic [DW-1:0] dev_addr,
    input logic          commit,
    input logic          cap_sel
);
    // R1
    rst_ptr_zero_chk: assert property (@(posedge clk) !rst_n |-> (ptr == '0));

    // R1
    rst_bus_release_chk: assert property (@(posedge clk) !rst_n |-> (bus_en == '0));

    // R7
    idle_bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && rd_n) |-> (bus_en == '0));

    // R2
    ptr_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> $past(commit && !cap_sel));

    // R9
    dev_addr_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> $past(commit && cap_sel));

    // R3
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R10
    serial_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && $past(serial_mode)) |-> !commit);
endmodule

bind host_regport hrp_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .rd_n(rd_n),
    .bus_en(bus_en), .ptr(ptr), .dev_addr(dev_addr),
    .commit(commit), .cap_sel(cap_sel)
);

// File: tb/sim_host_regport.sv
module sim_host_regport;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;
    localparam int WDOG       = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_n = 1'b1, wr_n = 1'b1, dsel = 1'b0, serial_mode = 1'b0;
    logic [7:0] tb_en = 8'h00, tb_out = 8'h00;
    wire  [7:0] hbus;
    logic [7:0] dev_addr;
    logic [127:0] cfg_bus;
    int checks = 0, fails = 0, cyc = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar b = 0; b < 8; b++) begin : g_drv
        assign hbus[b] = tb_en[b] ? tb_out[b] : 1'bz;
    end

    host_regport u0 (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .dsel(dsel),
        .serial_mode(serial_mode), .hbus(hbus), .dev_addr(dev_addr), .cfg_bus(cfg_bus)
    );

    // Vector: {is_read, dsel, data, expected}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h03, 8'h00},  // R2 pointer <- 3
        {1'b0, 1'b1, 8'hA5, 8'h00},  // R3 reg3 <- A5
        {1'b1, 1'b1, 8'h00, 8'hA5},  // R4 read reg3
        {1'b1, 1'b0, 8'h00, 8'h03},  // R5 read pointer
        {1'b0, 1'b1, 8'h3C, 8'h00},  // R6 same reg again
        {1'b1, 1'b1, 8'h00, 8'h3C},  // R6 read reg3
        {1'b0, 1'b0, 8'h0F, 8'h00},  // R2 pointer <- 15
        {1'b0, 1'b1, 8'h55, 8'h00},  // R9 dev address <- 55
        {1'b1, 1'b1, 8'h00, 8'h55},  // R9 read back
        {1'b0, 1'b0, 8'h10, 8'h00},  // R8 pointer out of range
        {1'b0, 1'b1, 8'h77, 8'h00},  // R8 ignored write
        {1'b1, 1'b1, 8'h00, 8'h00},  // R8 read zero
        {1'b1, 1'b0, 8'h00, 8'h10},  // R5 pointer kept
        {1'b0, 1'b0, 8'h03, 8'h00},  // R2 pointer <- 3
        {1'b1, 1'b1, 8'h00, 8'h3C}   // R8 reg3 untouched
    };

    function automatic string row_req(input int i);
        case (i)
            0, 6, 13:  return "R2";
            1:         return "R3";
            2:         return "R4";
            3, 12:     return "R5";
            4, 5:      return "R6";
            7, 8:      return "R9";
            default:   return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_cycle(input logic s, input logic [7:0] d);
        dsel = s; tb_out = d; tb_en = 8'hFF;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        tb_en = 8'h00;
    endtask

    task automatic rd_cycle(input logic s, output logic [7:0] v);
        tb_en = 8'h00; dsel = s;
        @(negedge clk);
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        v = hbus;
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        // R1 reset state with bench driving a pattern
        tb_en = 8'hFF; tb_out = 8'hC3;
        repeat (4) @(negedge clk);
        check("R1", hbus, 8'hC3);
        check("R1", dev_addr, 8'h2A);
        check("R1", cfg_bus[7:0], 8'h00);
        tb_en = 8'h00;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_cycle(1'b0, v); check("R1", v, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][17]) begin
                rd_cycle(VEC[i][16], v);
                check(row_req(i), v, VEC[i][7:0]);
            end else begin
                wr_cycle(VEC[i][16], VEC[i][15:8]);
            end
        end
        check("R4", cfg_bus[31:24], 8'h3C);
        check("R9", dev_addr, 8'h55);

        // R7 bus released when idle
        tb_en = 8'hFF; tb_out = 8'h96;
        repeat (2) @(negedge clk);
        check("R7", hbus, 8'h96);
        tb_en = 8'h00;

        // R3 no update while strobe low, update after rise
        wr_cycle(1'b0, 8'h0F);
        dsel = 1'b1; tb_out = 8'h11; tb_en = 8'hFF;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R3", dev_addr, 8'h55);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        tb_en = 8'h00;
        check("R3", dev_addr, 8'h11);

        // R10 GPIO output in serial mode
        wr_cycle(1'b0, 8'h0C); wr_cycle(1'b1, 8'hF0);
        wr_cycle(1'b0, 8'h0D); wr_cycle(1'b1, 8'hA0);
        serial_mode = 1'b1; tb_en = 8'h0F; tb_out = 8'h05;
        repeat (6) @(negedge clk);
        check("R10", hbus, 8'hA5);
        dsel = 1'b1;
        wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        tb_en = 8'h00; serial_mode = 1'b0;
        repeat (2) @(negedge clk);
        rd_cycle(1'b1, v); check("R10", v, 8'hA0);

        // R11 input register captured in serial mode, read-only
        wr_cycle(1'b0, 8'h0E);
        rd_cycle(1'b1, v); check("R11", v, 8'hA5);
        wr_cycle(1'b1, 8'hFF);
        rd_cycle(1'b1, v); check("R11", v, 8'hA5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule